// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block tells the fetch stage which address to fetch next. It keeps a small direct-mapped table of recently seen taken branches. Each table slot holds a valid flag, an address tag, the branch target and a two-bit saturating direction counter. Every cycle the current fetch address is looked up. A miss means the fetched word is treated as an ordinary instruction, and the block predicts the sequential address. A hit supplies the stored target, and the counter decides whether that target or the sequential address is used.

When the execute stage resolves a branch, it presents the branch address, the real outcome, the real target and the next address that the fetch stage predicted for that branch. In the same cycle the block reports whether the prediction was wrong, and gives the address fetch must restart from. At the next clock edge it trains the table. The counter provides hysteresis: starting from a strong state, one odd outcome cannot reverse a firmly biased branch.

The update port carries one resolved branch per cycle, marked by `upd_valid`. It is never back-pressured: the table takes an update on every cycle in which `upd_valid` is high, so the port has no ready signal. The lookup side is a plain combinational path from `fetch_pc` to the prediction outputs.

Top module: `btb_predictor`

## Requirements
- R1: When the fetch address misses, `pred_hit` is 0, `pred_taken` is 0 and `pred_npc` is `fetch_pc + 4`.
- R2: When the fetch address hits, `pred_hit` is 1. If the counter's upper bit is 1, `pred_taken` is 1 and `pred_npc` is the stored target. Otherwise `pred_taken` is 0 and `pred_npc` is `fetch_pc + 4`.
- R3: The counter is encoded as 3 = strongly taken, 2 = weakly taken, 1 = weakly not-taken and 0 = strongly not-taken. A taken update adds one, stopping at 3. A not-taken update subtracts one, stopping at 0.
- R4: From a strong state, one opposite outcome leaves the predicted direction unchanged. A second consecutive opposite outcome reverses it.
- R5: The table has 16 slots, selected by address bits [5:2]. Address bits [31:6] form the tag. An address that selects an occupied slot whose tag differs is a miss.
- R6: A taken update that misses fills the slot. It writes the valid flag, the tag, the resolved target and counter value 2 (weakly taken), and overwrites any previous occupant.
- R7: A not-taken update that misses leaves the table unchanged.
- R8: An update that hits steps the counter according to R3 and replaces the stored target with the resolved target.
- R9: `mispredict` is 1 exactly when `upd_valid` is 1 and `upd_pred_npc` differs from the resolved next address. The resolved next address is `upd_target` when the branch was taken, and `upd_pc + 4` otherwise. While `mispredict` is 1, `redirect_pc` carries the resolved next address.
- R10: Reset clears every valid flag, so every lookup in the first cycle after reset misses.
- R11: An update changes lookups from the following cycle on. A lookup in the same cycle as an update sees the table as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Address currently being fetched |
| pred_hit | output | 1 | Lookup found a valid slot with a matching tag |
| pred_taken | output | 1 | Prediction is to take the stored target |
| pred_npc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the branch |
| upd_target | input | 32 | Actual target of the branch |
| upd_pred_npc | input | 32 | Next address that fetch predicted for this branch |
| mispredict | output | 1 | Prediction was wrong; the younger work must be flushed |
| redirect_pc | output | 32 | Correct next fetch address |

## Verification
The bench drives counters into both saturation limits and then reverses the outcome. A counter that wrapped instead of saturating would flip direction after a single reversal, or would predict taken from the strongly-not-taken state. Aliasing addresses that share slot bits but differ in tag are mixed in, to catch a design that compares too few tag bits or forgets to replace the occupant. The bench also checks that a not-taken miss allocates nothing, that a new slot starts weak, and that a lookup in the same cycle as an update still sees the old contents. A long pseudo-random stream of updates over a small address pool then compares predictions and redirect outputs against an arithmetic model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] dir_ctr_t;

  localparam dir_ctr_t DIR_WEAK_TAKEN = 2'b10;
  localparam dir_ctr_t DIR_MAX        = 2'b11;
  localparam dir_ctr_t DIR_MIN        = 2'b00;

  function automatic dir_ctr_t dir_step(dir_ctr_t cur, logic taken);
    dir_ctr_t nxt;
    if (taken) nxt = (cur == DIR_MAX) ? DIR_MAX : dir_ctr_t'(cur + 2'd1);
    else       nxt = (cur == DIR_MIN) ? DIR_MIN : dir_ctr_t'(cur - 2'd1);
    return nxt;
  endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] fa_idx,
  output logic             fa_valid,
  output logic [TAG_W-1:0] fa_tag,
  output logic [PC_W-1:0]  fa_tgt,
  output dir_ctr_t         fa_ctr,
  input  logic [IDX_W-1:0] ua_idx,
  output logic             ua_valid,
  output logic [TAG_W-1:0] ua_tag,
  output logic [PC_W-1:0]  ua_tgt,
  output dir_ctr_t         ua_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  dir_ctr_t         wr_ctr
);
  localparam int SLOTS = 1 << IDX_W;

  logic             vld_q [SLOTS];
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [PC_W-1:0]  tgt_q [SLOTS];
  dir_ctr_t         ctr_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) vld_q[s] <= 1'b0;
      else if (sel) vld_q[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst && sel) begin
        tag_q[s] <= wr_tag;
        tgt_q[s] <= wr_tgt;
        ctr_q[s] <= wr_ctr;
      end
    end
  end

  assign fa_valid = vld_q[fa_idx];
  assign fa_tag   = tag_q[fa_idx];
  assign fa_tgt   = tgt_q[fa_idx];
  assign fa_ctr   = ctr_q[fa_idx];
  assign ua_valid = vld_q[ua_idx];
  assign ua_tag   = tag_q[ua_idx];
  assign ua_tgt   = tgt_q[ua_idx];
  assign ua_ctr   = ctr_q[ua_idx];

  // R11: a written slot reads back as occupied on the following cycle
  a_r11_write_visible: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] slot_idx,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [PC_W-1:0]  slot_tgt,
  input  dir_ctr_t         slot_ctr,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  npc
);
  logic [PC_W-1:0] seq_pc;

  assign slot_idx = fetch_pc[IDX_W+1:2];
  assign seq_pc   = fetch_pc + PC_W'(4);

  always_comb begin
    hit   = slot_valid && (slot_tag == fetch_pc[PC_W-1:IDX_W+2]);
    taken = hit && slot_ctr[1];
    npc   = taken ? slot_tgt : seq_pc;
  end

  // R1: a miss always falls through to the sequential address
  a_r1_miss_sequential: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (npc == fetch_pc + PC_W'(4)) && !taken);
  // R2: a taken prediction only comes from a hit
  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (rst)
    taken |-> hit && npc == slot_tgt);
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_target,
  input  logic [PC_W-1:0]  upd_pred_npc,
  output logic [IDX_W-1:0] slot_idx,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  dir_ctr_t         slot_ctr,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_tgt,
  output dir_ctr_t         wr_ctr,
  output logic             mispredict,
  output logic [PC_W-1:0]  redirect_pc
);
  logic            slot_hit;
  logic [PC_W-1:0] resolved_npc;

  assign slot_idx = upd_pc[IDX_W+1:2];
  assign wr_tag   = upd_pc[PC_W-1:IDX_W+2];
  assign wr_tgt   = upd_target;
  assign slot_hit = slot_valid && (slot_tag == wr_tag);

  always_comb begin
    wr_en  = 1'b0;
    wr_ctr = DIR_WEAK_TAKEN;
    if (upd_valid) begin
      if (slot_hit) begin
        wr_en  = 1'b1;
        wr_ctr = dir_step(slot_ctr, upd_taken);
      end else if (upd_taken) begin
        wr_en  = 1'b1;
        wr_ctr = DIR_WEAK_TAKEN;
      end
    end
  end

  assign resolved_npc = upd_taken ? upd_target : (upd_pc + PC_W'(4));
  assign mispredict   = upd_valid && (resolved_npc != upd_pred_npc);
  assign redirect_pc  = resolved_npc;

  // R7: a not-taken branch that misses never writes the table
  a_r7_no_fill_not_taken: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !slot_hit && !upd_taken) |-> !wr_en);
  // R6: a fresh fill starts weakly taken
  a_r6_fill_weak: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !slot_hit && upd_taken) |-> wr_en && wr_ctr == DIR_WEAK_TAKEN);
  // R3: the counter moves by at most one step, in the direction of the outcome
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && slot_hit) |->
      (upd_taken ? (wr_ctr >= slot_ctr && wr_ctr - slot_ctr <= 2'd1)
                 : (wr_ctr <= slot_ctr && slot_ctr - wr_ctr <= 2'd1)));
  // R9: no flush request without a resolved branch
  a_r9_flush_needs_update: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> upd_valid);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_npc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_npc,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic             f_valid, u_valid;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic [PC_W-1:0]  f_tgt, u_tgt;
  dir_ctr_t         f_ctr, u_ctr;
  logic             w_en;
  logic [TAG_W-1:0] w_tag;
  logic [PC_W-1:0]  w_tgt;
  dir_ctr_t         w_ctr;

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst(rst),
    .fa_idx(f_idx), .fa_valid(f_valid), .fa_tag(f_tag), .fa_tgt(f_tgt), .fa_ctr(f_ctr),
    .ua_idx(u_idx), .ua_valid(u_valid), .ua_tag(u_tag), .ua_tgt(u_tgt), .ua_ctr(u_ctr),
    .wr_en(w_en), .wr_idx(u_idx), .wr_tag(w_tag), .wr_tgt(w_tgt), .wr_ctr(w_ctr)
  );

  btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .slot_idx(f_idx), .slot_valid(f_valid), .slot_tag(f_tag),
    .slot_tgt(f_tgt), .slot_ctr(f_ctr),
    .hit(pred_hit), .taken(pred_taken), .npc(pred_npc)
  );

  btb_resolve #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_resolve (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_npc(upd_pred_npc),
    .slot_idx(u_idx), .slot_valid(u_valid), .slot_tag(u_tag), .slot_ctr(u_ctr),
    .wr_en(w_en), .wr_tag(w_tag), .wr_tgt(w_tgt), .wr_ctr(w_ctr),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  logic unused_tgt;
  assign unused_tgt = ^u_tgt;

  // R10: the first lookup after reset release misses
  a_r10_reset_empty: assert property (@(posedge clk)
    $fell(rst) |-> !pred_hit);
endmodule

// File: tb/btb_predictor_tb.sv
module btb_predictor_tb;
  localparam int SLOTS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit, pred_taken, mispredict;
  logic [31:0] pred_npc, redirect_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [31:0] upd_pred_npc = '0;

  int n_cmp = 0;
  int n_bad = 0;

  logic        m_vld [SLOTS];
  logic [25:0] m_tag [SLOTS];
  logic [31:0] m_tgt [SLOTS];
  logic [1:0]  m_ctr [SLOTS];

  btb_predictor u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_npc(pred_npc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_npc(upd_pred_npc),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  always #5 clk = ~clk;

  task automatic check(string lbl, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", lbl, act, exp);
    end
  endtask

  task automatic model_pred(logic [31:0] pc, output logic hit, output logic tk,
                            output logic [31:0] npc);
    int i;
    i   = int'(pc[5:2]);
    hit = m_vld[i] && (m_tag[i] == pc[31:6]);
    tk  = hit && m_ctr[i][1];
    npc = tk ? m_tgt[i] : pc + 32'd4;
  endtask

  task automatic model_upd(logic [31:0] pc, logic tk, logic [31:0] tgt);
    int i;
    i = int'(pc[5:2]);
    if (m_vld[i] && m_tag[i] == pc[31:6]) begin
      if (tk) m_ctr[i] = (m_ctr[i] == 2'd3) ? 2'd3 : m_ctr[i] + 2'd1;
      else    m_ctr[i] = (m_ctr[i] == 2'd0) ? 2'd0 : m_ctr[i] - 2'd1;
      m_tgt[i] = tgt;
    end else if (tk) begin
      m_vld[i] = 1'b1; m_tag[i] = pc[31:6]; m_tgt[i] = tgt; m_ctr[i] = 2'd2;
    end
  endtask

  task automatic step(string lbl, logic [31:0] fpc, logic uv, logic [31:0] upc,
                      logic tk, logic [31:0] tgt);
    logic e_hit, e_tk, u_hit, u_tk;
    logic [31:0] e_npc, u_npc, res;
    @(negedge clk);
    model_pred(fpc, e_hit, e_tk, e_npc);
    model_pred(upc, u_hit, u_tk, u_npc);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = tk;
    upd_target = tgt; upd_pred_npc = u_npc;
    #1;
    res = tk ? tgt : upc + 32'd4;
    check({lbl, " hit"}, 32'(pred_hit), 32'(e_hit));
    check({lbl, " taken"}, 32'(pred_taken), 32'(e_tk));
    check({lbl, " npc"}, pred_npc, e_npc);
    check({lbl, " R9 mispredict"}, 32'(mispredict), 32'(uv && res != u_npc));
    if (uv && res != u_npc) check({lbl, " R9 redirect"}, redirect_pc, res);
    if (uv) model_upd(upc, tk, tgt);
  endtask

  task automatic probe(string lbl, logic [31:0] pc, logic exp_tk, logic [31:0] exp_npc);
    step(lbl, pc, 1'b0, 32'h0, 1'b0, 32'h0);
    check({lbl, " direct taken"}, 32'(pred_taken), 32'(exp_tk));
    check({lbl, " direct npc"}, pred_npc, exp_npc);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b, lf;
    for (int i = 0; i < SLOTS; i++) begin
      m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    a = 32'h0000_1040;             // slot 0
    b = a + 32'h40;                // same slot, other tag
    // R10: nothing hits right after reset
    probe("R10", a, 1'b0, a + 4);
    // R1: misses across every slot
    for (int s = 0; s < SLOTS; s++) probe("R1", 32'h0000_2000 + 32'(s * 4), 1'b0, 32'h0000_2004 + 32'(s * 4));
    // R7: not-taken miss allocates nothing
    step("R7", a, 1'b1, a, 1'b0, 32'h0000_8000);
    step("R7 after", a, 1'b0, 0, 0, 0);
    check("R7 stays miss", 32'(pred_hit), 0);
    // R6: taken miss fills weakly taken
    step("R6", a, 1'b1, a, 1'b1, 32'h0000_8000);
    probe("R6 fill", a, 1'b1, 32'h0000_8000);
    step("R6 weak", a, 1'b1, a, 1'b0, 32'h0000_8000);
    probe("R6 weak flips", a, 1'b0, a + 4);
    check("R2 hit not taken", 32'(pred_hit), 1);
    // R3 / R4: saturate high, then reverse
    for (int k = 0; k < 4; k++) step("R3 up", a, 1'b1, a, 1'b1, 32'h0000_8000);
    step("R4 one", a, 1'b1, a, 1'b0, 32'h0000_8000);
    probe("R4 still taken", a, 1'b1, 32'h0000_8000);
    step("R4 two", a, 1'b1, a, 1'b0, 32'h0000_8000);
    probe("R4 flipped", a, 1'b0, a + 4);
    for (int k = 0; k < 3; k++) step("R3 down", a, 1'b1, a, 1'b0, 32'h0000_8000);
    probe("R3 low sat", a, 1'b0, a + 4);
    step("R4 one up", a, 1'b1, a, 1'b1, 32'h0000_8000);
    probe("R4 still not", a, 1'b0, a + 4);
    step("R4 two up", a, 1'b1, a, 1'b1, 32'h0000_8000);
    probe("R4 up flipped", a, 1'b1, 32'h0000_8000);
    // R8: hit update replaces the target
    step("R8", a, 1'b1, a, 1'b1, 32'h0000_9ABC);
    probe("R8 new target", a, 1'b1, 32'h0000_9ABC);
    // R5: alias in the same slot
    probe("R5 alias miss", b, 1'b0, b + 4);
    step("R5 replace", b, 1'b1, b, 1'b1, 32'h0000_7000);
    probe("R5 new owner", b, 1'b1, 32'h0000_7000);
    probe("R5 old evicted", a, 1'b0, a + 4);
    // R11: same-cycle lookup sees the old contents
    step("R11 same cycle", b, 1'b1, b, 1'b1, 32'h0000_7100);
    probe("R11 next cycle", b, 1'b1, 32'h0000_7100);
    // sweep: pseudo-random updates over a small pool (slots x 4 tags)
    lf = 32'hACE1_2345;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] up, fp, tg;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      up = {24'h0, lf[7:6], lf[5:2], 2'b00} + 32'h0000_4000;
      fp = {24'h0, lf[15:14], lf[13:10], 2'b00} + 32'h0000_4000;
      tg = {16'h0, lf[27:20], 8'h10};
      step("R9 sweep", fp, lf[17] | lf[18], up, lf[19] ^ lf[9], tg);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule